// File: doc/BRIEF.md
# Bridge Upstream Request Gate

This block guards the upstream direction of a virtual PCI-to-PCI bridge port. It holds the port's 16-bit command register. Three of its bits can be written: the bus-master permit, the memory window enable and the I/O window enable. The two window enables are driven straight out to the address decode logic that sits next to the gate.

Requests from the secondary side pass through a one-deep valid/ready register slice. When bus mastering is permitted, each request leaves unchanged. When it is not permitted, each request is neutralised. Write-class traffic, which includes MSI, becomes a memory write to a fixed sink address with every byte enable cleared. A read becomes a memory read of that same sink address. Its tag is remembered, so that the completion returning from the primary side for that tag reaches the secondary side with Unsupported Request status. All other completions travel downstream untouched, whatever the permit bit holds.

Top module: `upstream_req_gate`

## Requirements
- R1: After reset, the command register reads 0000h, both window enables are low, `out_valid` is low and `in_ready` is high.
- R2: A command write updates bits 2:0 only, and only when `cfg_wr_be[0]` is set. All other bits always read zero. A write with `cfg_wr_be[0]` clear changes nothing.
- R3: `mem_win_en` follows command bit 1 and `io_win_en` follows command bit 0.
- R4: With command bit 2 set, an accepted request appears on the output one cycle later with the same type, address, byte enables and tag. Type codes: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 MSI.
- R5: With bit 2 clear, a request of any type other than 0 or 2 leaves as type 1, at address C0000h, with byte enables all zero and the original tag.
- R6: With bit 2 clear, a request of type 0 or 2 leaves as type 0, at address C0000h, with its original byte enables and tag.
- R7: A completion whose tag belongs to a read blocked under R6 appears on `scpl_status` as Unsupported Request (code 1). This holds until that completion is handed over (`pcpl_valid` and `scpl_ready` both high). After that the tag reports its real status again. A later read with the same tag accepted while bit 2 is set also clears the mark.
- R8: Completions for tags that are not marked pass to the secondary side in the same cycle, with valid, tag, status and ready unchanged, whatever the value of bit 2.
- R9: Bit 2 is sampled when a request is accepted. A request accepted on the same edge as a command write is handled under the old value.
- R10: While `out_valid` is high and `out_ready` is low, the output request holds stable and `in_ready` is low, so no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Command register write strobe |
| cfg_wr_be | input | 2 | Byte enables of the write |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_data | output | 16 | Current command register value |
| mem_win_en | output | 1 | Memory and prefetchable window enable |
| io_win_en | output | 1 | I/O window enable |
| in_valid | input | 1 | Secondary-side request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_type | input | 3 | Request type code |
| in_addr | input | ADDR_W | Request address |
| in_be | input | BE_W | Request byte enables |
| in_tag | input | TAG_W | Request tag |
| out_valid | output | 1 | Primary-side request valid |
| out_ready | input | 1 | Primary side takes the request |
| out_type | output | 3 | Forwarded type |
| out_addr | output | ADDR_W | Forwarded address |
| out_be | output | BE_W | Forwarded byte enables |
| out_tag | output | TAG_W | Forwarded tag |
| pcpl_valid | input | 1 | Completion from the primary side valid |
| pcpl_ready | output | 1 | Completion taken |
| pcpl_tag | input | TAG_W | Completion tag |
| pcpl_status | input | ST_W | Completion status |
| scpl_valid | output | 1 | Completion toward the secondary side valid |
| scpl_ready | input | 1 | Secondary side takes the completion |
| scpl_tag | output | TAG_W | Completion tag |
| scpl_status | output | ST_W | Completion status, possibly forced to UR |

## Verification
The bench targets these corner cases:
- A command write and a request acceptance on the same edge. A gate that looked at the new permit value would let through a request it should have blocked.
- Blocked I/O reads, and MSI treated as a write. A design that kept the I/O type or left MSI byte enables set would put live traffic on the primary bus.
- A UR completion held back by `scpl_ready`, then handed over, then the same tag seen again. A tag mark that clears too early, or never clears, shows up as the wrong status.
- Reuse of a tag by a permitted read, and a back-pressured output slot. A slice that overwrote its held entry would lose a request.

// File: rtl/upstream_req_gate.sv
module upstream_req_gate #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int TAG_W  = 5,
  parameter int ST_W   = 3,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_be,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  output logic              mem_win_en,
  output logic              io_win_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BE_W-1:0]   out_be,
  output logic [TAG_W-1:0]  out_tag,
  input  logic              pcpl_valid,
  output logic              pcpl_ready,
  input  logic [TAG_W-1:0]  pcpl_tag,
  input  logic [ST_W-1:0]   pcpl_status,
  output logic              scpl_valid,
  input  logic              scpl_ready,
  output logic [TAG_W-1:0]  scpl_tag,
  output logic [ST_W-1:0]   scpl_status
);

  localparam int NTAG = 1 << TAG_W;
  localparam logic [2:0] TY_MRD  = 3'd0;
  localparam logic [2:0] TY_MWR  = 3'd1;
  localparam logic [2:0] TY_IORD = 3'd2;
  localparam logic [ST_W-1:0] ST_UR = ST_W'(1);

  logic [2:0]      en_q;
  logic [NTAG-1:0] ur_pend;

  wire bme   = en_q[2];
  wire take  = in_valid && in_ready;
  wire is_rd = (in_type == TY_MRD) || (in_type == TY_IORD);
  wire cpl_x = pcpl_valid && scpl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (cfg_wr_en && cfg_wr_be[0])
      en_q <= cfg_wr_data[2:0];
  end

  assign cfg_rd_data = {13'd0, en_q};
  assign mem_win_en  = en_q[1];
  assign io_win_en   = en_q[0];
  assign in_ready    = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_addr  <= '0;
      out_be    <= '0;
      out_tag   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_tag   <= in_tag;
      if (bme) begin
        out_type <= in_type;
        out_addr <= in_addr;
        out_be   <= in_be;
      end else if (is_rd) begin
        out_type <= TY_MRD;
        out_addr <= SINK_ADDR;
        out_be   <= in_be;
      end else begin
        out_type <= TY_MWR;
        out_addr <= SINK_ADDR;
        out_be   <= '0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ur_pend <= '0;
    else begin
      if (cpl_x)
        ur_pend[pcpl_tag] <= 1'b0;
      if (take && is_rd)
        ur_pend[in_tag] <= !bme;
    end
  end

  assign scpl_valid  = pcpl_valid;
  assign pcpl_ready  = scpl_ready;
  assign scpl_tag    = pcpl_tag;
  assign scpl_status = ur_pend[pcpl_tag] ? ST_UR : pcpl_status;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bme) |=> (out_valid && out_addr == $past(in_addr) && out_be == $past(in_be) && out_tag == $past(in_tag))); // R4

  AST_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bme && !is_rd) |=> (out_type == TY_MWR && out_addr == SINK_ADDR && out_be == '0)); // R5

  AST_BLOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bme && is_rd) |=> (out_type == TY_MRD && out_addr == SINK_ADDR && out_tag == $past(in_tag))); // R6

  AST_UR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bme && is_rd) |=> (pcpl_tag != $past(in_tag) || scpl_status == ST_UR)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag) && $stable(out_type))); // R10

endmodule

// File: tb/test_upstream_req_gate.sv
module test_upstream_req_gate;
  localparam int AW = 32, BW = 4, TW = 5, SW = 3;
  localparam logic [31:0] SINK = 32'h000C_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_be = '0;
  logic [15:0] cfg_wr_data = '0, cfg_rd_data;
  logic mem_win_en, io_win_en;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_type = '0, out_type;
  logic [AW-1:0] in_addr = '0, out_addr;
  logic [BW-1:0] in_be = '0, out_be;
  logic [TW-1:0] in_tag = '0, out_tag;
  logic out_valid, out_ready = 1'b1;
  logic pcpl_valid = 1'b0, pcpl_ready;
  logic [TW-1:0] pcpl_tag = '0, scpl_tag;
  logic [SW-1:0] pcpl_status = '0, scpl_status;
  logic scpl_valid, scpl_ready = 1'b0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  upstream_req_gate i_upstream_req_gate (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .mem_win_en(mem_win_en), .io_win_en(io_win_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_addr(in_addr), .in_be(in_be), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_addr(out_addr), .out_be(out_be), .out_tag(out_tag),
    .pcpl_valid(pcpl_valid), .pcpl_ready(pcpl_ready), .pcpl_tag(pcpl_tag), .pcpl_status(pcpl_status),
    .scpl_valid(scpl_valid), .scpl_ready(scpl_ready), .scpl_tag(scpl_tag), .scpl_status(scpl_status));

  // {bme, type, addr, be, tag, exp_type, exp_addr, exp_be}
  localparam logic [83:0] VEC [0:8] = '{
    {1'b1, 3'd0, 32'h1000_0040, 4'hF, 5'd3,  3'd0, 32'h1000_0040, 4'hF},
    {1'b1, 3'd1, 32'h2000_0104, 4'h3, 5'd4,  3'd1, 32'h2000_0104, 4'h3},
    {1'b1, 3'd3, 32'h0000_0CF8, 4'h1, 5'd5,  3'd3, 32'h0000_0CF8, 4'h1},
    {1'b1, 3'd4, 32'hFEE0_0000, 4'hF, 5'd6,  3'd4, 32'hFEE0_0000, 4'hF},
    {1'b0, 3'd1, 32'h3000_0000, 4'hF, 5'd7,  3'd1, SINK,          4'h0},
    {1'b0, 3'd3, 32'h0000_0080, 4'h1, 5'd8,  3'd1, SINK,          4'h0},
    {1'b0, 3'd4, 32'hFEE0_1000, 4'hF, 5'd10, 3'd1, SINK,          4'h0},
    {1'b0, 3'd0, 32'h4000_0010, 4'h3, 5'd11, 3'd0, SINK,          4'h3},
    {1'b0, 3'd2, 32'h0000_0060, 4'h1, 5'd12, 3'd0, SINK,          4'h1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] be, input logic [15:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_be = be; cfg_wr_data = data;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic send(input logic [2:0] ty, input logic [31:0] ad, input logic [3:0] be, input logic [4:0] tg);
    @(negedge clk);
    in_valid = 1'b1; in_type = ty; in_addr = ad; in_be = be; in_tag = tg;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rd_data == 16'h0000, "R1 cmd", cfg_rd_data, 0);
    check(!mem_win_en && !io_win_en, "R1 windows", {mem_win_en, io_win_en}, 0);
    check(!out_valid && in_ready, "R1 slot", {out_valid, in_ready}, 1);

    cfg_write(2'b11, 16'hFFFF);
    check(cfg_rd_data == 16'h0007, "R2 all ones", cfg_rd_data, 16'h0007);
    cfg_write(2'b10, 16'h0000);
    check(cfg_rd_data == 16'h0007, "R2 byte0 off ignored", cfg_rd_data, 16'h0007);
    cfg_write(2'b01, 16'h00FA);
    check(cfg_rd_data == 16'h0002, "R2 partial", cfg_rd_data, 16'h0002);
    check(mem_win_en == 1'b1 && io_win_en == 1'b0, "R3 mem only", {mem_win_en, io_win_en}, 2'b10);
    cfg_write(2'b01, 16'h0001);
    check(mem_win_en == 1'b0 && io_win_en == 1'b1, "R3 io only", {mem_win_en, io_win_en}, 2'b01);

    for (int i = 0; i < 9; i++) begin
      logic [83:0] v;
      string rq;
      v = VEC[i];
      rq = v[83] ? "R4" : ((v[82:80] == 3'd0 || v[82:80] == 3'd2) ? "R6" : "R5");
      cfg_write(2'b01, {13'd0, v[83], 2'b11});
      send(v[82:80], v[79:48], v[47:44], v[43:39]);
      check(out_valid, rq, out_valid, 1);
      check(out_type == v[38:36], rq, out_type, v[38:36]);
      check(out_addr == v[35:4], rq, out_addr, v[35:4]);
      check(out_be == v[3:0], rq, out_be, v[3:0]);
      check(out_tag == v[43:39], rq, out_tag, v[43:39]);
    end

    // R9: write enabling bus mastering on the same edge as acceptance
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_be = 2'b01; cfg_wr_data = 16'h0007;
    in_valid = 1'b1; in_type = 3'd1; in_addr = 32'h5000_0000; in_be = 4'hF; in_tag = 5'd13;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0; in_valid = 1'b0;
    check(out_addr == SINK && out_be == 4'h0, "R9 old value used", out_addr, SINK);
    send(3'd1, 32'h5000_0000, 4'hF, 5'd14);
    check(out_addr == 32'h5000_0000 && out_be == 4'hF, "R9 new value later", out_addr, 32'h5000_0000);

    // R10: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(3'd1, 32'h6000_0000, 4'hF, 5'd15);
    check(out_valid && !in_ready, "R10 stalled", {out_valid, in_ready}, 2'b10);
    in_valid = 1'b1; in_type = 3'd1; in_addr = 32'h7000_0000; in_be = 4'h1; in_tag = 5'd16;
    @(posedge clk);
    @(negedge clk);
    check(out_tag == 5'd15 && out_addr == 32'h6000_0000, "R10 held", out_tag, 5'd15);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_tag == 5'd16 && out_addr == 32'h7000_0000, "R10 next taken", out_tag, 5'd16);
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R10 drained", out_valid, 0);

    // R7 / R8: completion status handling
    cfg_write(2'b01, 16'h0003);
    send(3'd0, 32'h8000_0000, 4'hF, 5'd20);
    @(negedge clk);
    pcpl_valid = 1'b1; pcpl_tag = 5'd20; pcpl_status = 3'd0; scpl_ready = 1'b0;
    #1;
    check(scpl_status == 3'd1, "R7 forced UR", scpl_status, 1);
    check(!pcpl_ready && scpl_valid, "R8 handshake follows", {pcpl_ready, scpl_valid}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    check(scpl_status == 3'd1, "R7 kept while stalled", scpl_status, 1);
    scpl_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(scpl_status == 3'd0, "R7 cleared after handover", scpl_status, 0);
    pcpl_tag = 5'd21; pcpl_status = 3'd4;
    #1;
    check(scpl_status == 3'd4 && scpl_tag == 5'd21 && pcpl_ready, "R8 unmarked passes", scpl_status, 4);
    @(negedge clk);
    pcpl_valid = 1'b0;
    #1;
    check(!scpl_valid, "R8 valid follows", scpl_valid, 0);

    cfg_write(2'b01, 16'h0007);
    send(3'd0, 32'h9000_0000, 4'hF, 5'd11);
    @(negedge clk);
    pcpl_valid = 1'b1; pcpl_tag = 5'd11; pcpl_status = 3'd0;
    #1;
    check(scpl_status == 3'd0, "R7 mark cleared by permitted read", scpl_status, 0);
    pcpl_tag = 5'd12; pcpl_status = 3'd0;
    #1;
    check(scpl_status == 3'd1, "R7 earlier blocked io read", scpl_status, 1);
    @(negedge clk);
    pcpl_valid = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule